// File: doc/BRIEF.md
# Block Transfer Wait/Request Pin Controller

This block drives the two handshake pins that a serial channel uses for block transfers. The first pin is shared. Software sets it up either as an active-low wait line or as an active-low DMA request line. As a wait line it stretches a CPU access to a data buffer that cannot be served yet. As a request line it tells a DMA controller that the channel can move a byte. The second pin can be turned into an active-low DMA request for the transmitter. Each pin is controlled through a drive-low output and a high-impedance output, so the board can build open-drain or push-pull behaviour around it.

Software writes a 3-bit mode field with three parts: an enable bit, a function bit (wait or request) and a direction bit (transmit or receive). A separate write sets the enable for the second pin. The intended sequence is to choose the function and direction with the enable bit at 0, and then set the enable bit in a later write. Because the enable bit gates the pin, changing the fields while it is 0 never produces a pulse. After reset the shared pin is in wait mode for the transmitter, disabled and released.

Both pins are registered. Each one reflects the inputs and any register write of a cycle at the next rising clock edge.

Top module: `wreq_handshake`

## Requirements
- R1: After reset, both pins are released (drive-low 0, high-impedance 1). The mode field is 3'b000, which is wait, transmit, disabled. A later write of only the enable bit (3'b100) gives wait-on-transmit behaviour.
- R2: Mode field encoding is as follows. Bit 2 is the enable. Bit 1 selects the function: 1 is request, 0 is wait. Bit 0 selects the direction: 1 is receive, 0 is transmit. A write takes effect on the pin at the same clock edge that captures it.
- R3: While the enable bit is 0, the shared pin stays released whatever the function, direction, strobes or buffer flags are. Writing new function or direction values with the enable bit at 0 causes no pulse on the pin.
- R4: Wait on transmit works as follows. A write strobe while the transmit buffer is full drives the shared pin low from the next edge. The pin stays low while both conditions hold. It is released at the edge after the buffer stops being full or the strobe ends.
- R5: Wait on receive works as follows. A read strobe while no receive data is available drives the shared pin low from the next edge. It is released at the edge after data becomes available or the strobe ends.
- R6: In wait mode the inactive shared pin floats (high-impedance 1, drive-low 0). No pin is ever both driven low and high-impedance.
- R7: Transmit request mode (3'b110) drives the shared pin low while the transmit buffer is not full. It drives the pin high (both controls 0) while the buffer is full.
- R8: Receive request mode (3'b111) drives the shared pin low while receive data is available. It drives the pin high otherwise.
- R9: The second pin floats while its enable is 0. While its enable is 1 it is driven low when the transmit buffer is empty and no write strobe is present, and driven high otherwise. A write strobe therefore releases the request at the next edge.
- R10: A write that clears the enable bit releases the shared pin at that edge, even while a wait or request condition is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_we | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 3 | Mode field value: {enable, function, direction} |
| txreq_we | input | 1 | Write strobe for the second-pin enable |
| txreq_wdata | input | 1 | Second-pin transmit request enable |
| tx_full | input | 1 | Transmit buffer full |
| tx_empty | input | 1 | Transmit buffer empty |
| rx_avail | input | 1 | Receive data available |
| cpu_rd | input | 1 | CPU read strobe to the receive buffer |
| cpu_wr | input | 1 | CPU write strobe to the transmit buffer |
| pin_a_low | output | 1 | Shared pin: drive low |
| pin_a_hiz | output | 1 | Shared pin: high impedance |
| pin_b_low | output | 1 | Transmit request pin: drive low |
| pin_b_hiz | output | 1 | Transmit request pin: high impedance |

## Verification
Each of the four enabled modes is run with the buffer condition both present and absent, and with the access strobe both present and absent. This separates a pin that follows the buffer flag alone from one that also needs the strobe. Writes with the enable bit cleared are made while buffer conditions that would assert the pin are present, so any ungated path shows up as a pulse. The second pin is run through empty, write and non-empty patterns, which shows that a write strobe overrides the empty flag. A reset in the middle of an active wait shows both the release and the default mode.

// File: rtl/wreq_handshake.sv
module wreq_handshake (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic [2:0] mode_wdata,
  input  logic       txreq_we,
  input  logic       txreq_wdata,
  input  logic       tx_full,
  input  logic       tx_empty,
  input  logic       rx_avail,
  input  logic       cpu_rd,
  input  logic       cpu_wr,
  output logic       pin_a_low,
  output logic       pin_a_hiz,
  output logic       pin_b_low,
  output logic       pin_b_hiz
);

  logic [2:0] mode_q;
  logic       txreq_q;

  logic [2:0] mode_eff;
  logic       txreq_eff;
  logic       en, fn_req, dir_rx;
  logic       a_act, a_float, b_act;

  assign mode_eff  = mode_we  ? mode_wdata  : mode_q;
  assign txreq_eff = txreq_we ? txreq_wdata : txreq_q;

  assign en     = mode_eff[2];
  assign fn_req = mode_eff[1];
  assign dir_rx = mode_eff[0];

  always_comb begin
    if (!en)
      a_act = 1'b0;
    else if (fn_req)
      a_act = dir_rx ? rx_avail : !tx_full;
    else
      a_act = dir_rx ? (cpu_rd && !rx_avail) : (cpu_wr && tx_full);
  end

  assign a_float = !(en && (fn_req || a_act));
  assign b_act   = txreq_eff && tx_empty && !cpu_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 3'b000;
      txreq_q   <= 1'b0;
      pin_a_low <= 1'b0;
      pin_a_hiz <= 1'b1;
      pin_b_low <= 1'b0;
      pin_b_hiz <= 1'b1;
    end else begin
      mode_q    <= mode_eff;
      txreq_q   <= txreq_eff;
      pin_a_low <= a_act;
      pin_a_hiz <= a_float;
      pin_b_low <= b_act;
      pin_b_hiz <= !txreq_eff;
    end
  end

endmodule

module wreq_handshake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_we,
  input logic [2:0] mode_wdata,
  input logic       tx_full,
  input logic       rx_avail,
  input logic       cpu_rd,
  input logic       cpu_wr,
  input logic [2:0] mode_q,
  input logic       pin_a_low,
  input logic       pin_a_hiz,
  input logic       pin_b_low,
  input logic       pin_b_hiz
);

  p_quiet_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[2] && !(mode_we && mode_wdata[2])) |=> (pin_a_hiz && !pin_a_low));

  p_wait_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b100 && !mode_we && cpu_wr && tx_full) |=> pin_a_low);

  p_wait_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b101 && !mode_we && cpu_rd && !rx_avail) |=> pin_a_low);

  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pin_a_low && pin_a_hiz) && !(pin_b_low && pin_b_hiz));

  p_write_drops_txreq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> !pin_b_low);

  p_disable_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && !mode_wdata[2]) |=> (pin_a_hiz && !pin_a_low));

endmodule

bind wreq_handshake wreq_handshake_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
  .tx_full(tx_full), .rx_avail(rx_avail), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .mode_q(mode_q), .pin_a_low(pin_a_low), .pin_a_hiz(pin_a_hiz),
  .pin_b_low(pin_b_low), .pin_b_hiz(pin_b_hiz)
);

// File: tb/wreq_handshake_tb_top.sv
module wreq_handshake_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_we = 1'b0;
  logic [2:0] mode_wdata = 3'b000;
  logic txreq_we = 1'b0, txreq_wdata = 1'b0;
  logic tx_full = 1'b0, tx_empty = 1'b1, rx_avail = 1'b0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic pin_a_low, pin_a_hiz, pin_b_low, pin_b_hiz;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wreq_handshake dut_i (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .txreq_we(txreq_we), .txreq_wdata(txreq_wdata), .tx_full(tx_full),
    .tx_empty(tx_empty), .rx_avail(rx_avail), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .pin_a_low(pin_a_low), .pin_a_hiz(pin_a_hiz),
    .pin_b_low(pin_b_low), .pin_b_hiz(pin_b_hiz)
  );

  // layout: we | mode[3] | we2 | txr | full | empty | avail | rd | wr | pad | {a_low,a_hiz,b_low,b_hiz}
  localparam int NV = 25;
  localparam logic [15:0] VEC [NV] = '{
    16'b0_000_0_0_0_1_0_0_0_0_0101,
    16'b1_000_0_0_1_0_0_0_1_0_0101,
    16'b1_010_0_0_0_1_0_0_0_0_0101,
    16'b1_100_0_0_1_0_0_0_1_0_1001,
    16'b0_000_0_0_1_0_0_0_1_0_1001,
    16'b0_000_0_0_0_0_0_0_1_0_0101,
    16'b0_000_0_0_1_0_0_0_0_0_0101,
    16'b1_101_0_0_0_1_0_1_0_0_1001,
    16'b0_000_0_0_0_1_1_1_0_0_0101,
    16'b0_000_0_0_0_1_0_0_0_0_0101,
    16'b1_110_0_0_0_1_0_0_0_0_1001,
    16'b0_000_0_0_1_0_0_0_0_0_0001,
    16'b1_111_0_0_1_0_1_0_0_0_1001,
    16'b0_000_0_0_1_0_0_0_0_0_0001,
    16'b1_011_0_0_1_0_1_0_0_0_0101,
    16'b0_000_1_1_0_1_0_0_0_0_0110,
    16'b0_000_0_0_0_1_0_0_1_0_0100,
    16'b0_000_0_0_0_0_0_0_0_0_0100,
    16'b0_000_0_0_0_1_0_0_0_0_0110,
    16'b0_000_1_0_0_1_0_0_0_0_0101,
    16'b1_100_0_0_1_0_0_0_1_0_1001,
    16'b1_000_0_0_1_0_0_0_1_0_0101,
    16'b1_110_0_0_0_1_0_0_0_0_1001,
    16'b1_100_0_0_0_1_0_0_0_0_0101,
    16'b1_000_0_0_0_1_0_0_0_0_0101
  };
  localparam string TAG [NV] = '{
    "R1", "R3", "R3", "R4", "R4", "R4", "R6", "R5", "R5", "R6",
    "R7", "R7", "R8", "R8", "R10", "R9", "R9", "R9", "R9", "R9",
    "R4", "R10", "R2", "R2", "R3"
  };

  task automatic check(input string tag, input logic [3:0] exp);
    logic [3:0] got;
    got = {pin_a_low, pin_a_hiz, pin_b_low, pin_b_hiz};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s pins{a_low,a_hiz,b_low,b_hiz} actual=%b expected=%b", tag, got, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", 4'b0101);  // R1 released while in reset
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {mode_we, mode_wdata, txreq_we, txreq_wdata, tx_full, tx_empty,
       rx_avail, cpu_rd, cpu_wr} = VEC[i][15:5];
      @(posedge clk);
      #1;
      check(TAG[i], VEC[i][3:0]);
    end

    // R1: reset during an active wait releases the pin and restores the default mode
    @(negedge clk);
    mode_we = 1'b1; mode_wdata = 3'b100; tx_full = 1'b1; cpu_wr = 1'b1;
    @(posedge clk); #1;
    check("R4", 4'b1001);
    @(negedge clk);
    mode_we = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1", 4'b0101);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", 4'b0101);
    @(negedge clk);
    mode_we = 1'b1; mode_wdata = 3'b100;
    @(posedge clk); #1;
    check("R1", 4'b1001);
    @(negedge clk);
    mode_we = 1'b0; tx_full = 1'b0; cpu_wr = 1'b0;
    @(posedge clk); #1;
    check("R6", 4'b0101);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule